// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst memory access. A burst opens on one of two active-low start strobes: a processor strobe and a controller strobe. The block then loads the full external address and holds the upper bits for the whole burst. Only the two low bits are counted, in either linear or interleaved order, and the count wraps back to the starting value after the fourth beat. An active-low advance input steps the burst to its next beat or holds it on the current one.

Every rising edge is classified as a start, a continue (step), a suspend (hold) or a deselect, and the result is reported through registered one-hot flags. A sleep input freezes the sequencer. After sleep is released, a short wake window rejects start strobes while advance still works. The burst controller has two states, `BS_IDLE` and `BS_RUN`. A selected start moves either state to `BS_RUN`. A deselected start moves either state to `BS_IDLE`. An edge with no start leaves the state where it is. The power gate has three states: `PW_ON`, `PW_SLEEP` and `PW_WARM`. Sleep high moves `PW_ON` or `PW_WARM` to `PW_SLEEP`. Sleep low moves `PW_SLEEP` to `PW_WARM`. `PW_WARM` returns to `PW_ON` when its wake count is exhausted.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `word_addr_o` is 0, `beat_o` is 0 and all four event flags are 0.
- R2: When `strobe_cpu_n` is low, the three selects are active and the block is awake, the next output shows `start_o`=1, `word_addr_o` equal to `addr_i` and `beat_o`=0.
- R3: While `sel_a_n` is high, a low `strobe_cpu_n` has no effect. It starts nothing, flags no deselect, and a running burst steps or holds according to `advance_n`.
- R4: `strobe_ctl_n` low starts a burst only when `strobe_cpu_n` is high on the same edge. If both strobes are low and `sel_a_n` is high, nothing happens.
- R5: `advance_n` is ignored on an edge that honours a start, so `beat_o` is 0 after a start whatever the value of `advance_n`.
- R6: During a burst, `advance_n` low steps `beat_o` by one and sets `cont_o`. `advance_n` high holds the address and beat and sets `susp_o`.
- R7: Address bits 14:2 of `word_addr_o` equal those of `addr_i` sampled at the start, and stay fixed while `addr_i` changes during the burst.
- R8: With `ilv_mode_i`=1, the low two bits equal the starting low bits XOR `beat_o`. For example, a start of 01 gives 01,00,11,10.
- R9: With `ilv_mode_i`=0, the low two bits equal the starting low bits plus `beat_o`, modulo 4. For example, a start of 10 gives 10,11,00,01.
- R10: After the fourth beat, the next step wraps `beat_o` to 0 and the low bits back to their starting value.
- R11: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A start edge that is not selected sets `desel_o`, leaves the address unchanged and makes the burst idle, so later advance edges set no flag.
- R12: While `sleep_i` is high, all flags are 0 and the address and beat hold. On the first two edges after `sleep_i` returns low, start strobes are ignored. A start on the third edge is honoured.
- R13: With no burst running and no start, the address and beat hold and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 15 | External word address |
| strobe_cpu_n | input | 1 | Processor start strobe, active low |
| strobe_ctl_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Beat advance, active low |
| ilv_mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| sel_a_n | input | 1 | Primary select, active low; also gates the processor strobe |
| sel_b | input | 1 | Second select, active high |
| sel_c_n | input | 1 | Third select, active low |
| sleep_i | input | 1 | Sleep request, active high |
| word_addr_o | output | 15 | Current beat word address |
| beat_o | output | 2 | Beat index within the burst |
| start_o | output | 1 | Last edge opened a burst |
| cont_o | output | 1 | Last edge stepped the burst |
| susp_o | output | 1 | Last edge held the burst |
| desel_o | output | 1 | Last edge saw a start while not selected |

## Verification
The embedded properties check a set of rules on every cycle: the event flags are mutually exclusive, and a start loads the sampled address with beat zero. They also check that a step adds exactly one to the beat, a suspend freezes both address and beat, and the upper address bits never move inside a burst. Further properties confirm that no start appears while asleep and that the wake window blocks the start gate. Only the bench's scenarios can show other behaviour. These are the actual linear and interleaved orders, the wrap after four beats, and the priority of the two strobes when the primary select is high. The scenarios also cover the idle state after a deselect and the exact count of rejected edges after wake.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_RUN  = 1'b1
    } burst_st_e;

    typedef enum logic [1:0] {
        PW_ON    = 2'd0,
        PW_SLEEP = 2'd1,
        PW_WARM  = 2'd2
    } pwr_st_e;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_START = 3'd1,
        EV_DESEL = 3'd2,
        EV_STEP  = 3'd3,
        EV_HOLD  = 3'd4
    } edge_ev_e;

endpackage

// File: rtl/bsq_power_gate.sv
module bsq_power_gate
    import bsq_pkg::*;
#(
    parameter int WAKE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic hold_o,
    output logic start_ok_o
);

    localparam int CW = $clog2(WAKE_CYCLES) + 1;

    pwr_st_e        st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PW_ON: begin
                if (sleep_i) st_d = PW_SLEEP;
            end
            PW_SLEEP: begin
                if (!sleep_i) begin
                    st_d  = PW_WARM;
                    cnt_d = CW'(WAKE_CYCLES - 2);
                end
            end
            PW_WARM: begin
                if (sleep_i)             st_d  = PW_SLEEP;
                else if (cnt_q == '0)    st_d  = PW_ON;
                else                     cnt_d = cnt_q - 1'b1;
            end
            default: st_d = PW_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PW_ON;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign hold_o     = sleep_i;
    assign start_ok_o = (st_q == PW_ON) && !sleep_i;

    // R12: the second edge after sleep drops still refuses a start
    a_r12_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_i) |=> !start_ok_o);

endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    output logic [BW-1:0] beat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      beat_o <= '0;
        else if (load_i) beat_o <= '0;
        else if (step_i) beat_o <= beat_o + 1'b1;
    end

endmodule

// File: rtl/bsq_beat_map.sv
module bsq_beat_map #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] base_low_i,
    input  logic [BW-1:0] beat_i,
    input  logic          ilv_i,
    output logic [BW-1:0] low_o
);

    logic [BW-1:0] lin_low;
    logic [BW-1:0] ilv_low;

    always_comb begin
        lin_low = base_low_i + beat_i;
        ilv_low = base_low_i ^ beat_i;
        low_o   = ilv_i ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int AW          = 15,
    parameter int BW          = 2,
    parameter int WAKE_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          strobe_cpu_n,
    input  logic          strobe_ctl_n,
    input  logic          advance_n,
    input  logic          ilv_mode_i,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          sleep_i,
    output logic [AW-1:0] word_addr_o,
    output logic [BW-1:0] beat_o,
    output logic          start_o,
    output logic          cont_o,
    output logic          susp_o,
    output logic          desel_o
);

    localparam int HI_W = AW - BW;

    burst_st_e      st_q, st_d;
    edge_ev_e       ev;
    logic           hold, start_ok;
    logic           cpu_req, ctl_req, start_req, sel_ok;
    logic [AW-1:0]  base_q, base_nx;
    logic [BW-1:0]  beat_nx, low_nx;

    bsq_power_gate #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .hold_o     (hold),
        .start_ok_o (start_ok)
    );

    bsq_beat_counter #(.BW(BW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ev == EV_START),
        .step_i (ev == EV_STEP),
        .beat_o (beat_o)
    );

    bsq_beat_map #(.BW(BW)) u_map (
        .base_low_i (base_nx[BW-1:0]),
        .beat_i     (beat_nx),
        .ilv_i      (ilv_mode_i),
        .low_o      (low_nx)
    );

    // Strobe qualification and edge classification
    always_comb begin
        cpu_req   = !strobe_cpu_n && !sel_a_n;
        ctl_req   = !strobe_ctl_n && strobe_cpu_n;
        start_req = (cpu_req || ctl_req) && start_ok;
        sel_ok    = !sel_a_n && sel_b && !sel_c_n;
        if (hold)                ev = EV_NONE;
        else if (start_req)      ev = sel_ok ? EV_START : EV_DESEL;
        else if (st_q == BS_RUN) ev = advance_n ? EV_HOLD : EV_STEP;
        else                     ev = EV_NONE;
    end

    always_comb begin
        st_d = st_q;
        unique case (ev)
            EV_START: st_d = BS_RUN;
            EV_DESEL: st_d = BS_IDLE;
            EV_STEP,
            EV_HOLD,
            EV_NONE:  st_d = st_q;
            default:  st_d = st_q;
        endcase
    end

    always_comb begin
        base_nx = (ev == EV_START) ? addr_i : base_q;
        unique case (ev)
            EV_START: beat_nx = '0;
            EV_STEP:  beat_nx = beat_o + 1'b1;
            default:  beat_nx = beat_o;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BS_IDLE;
            base_q <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_nx;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr_o <= '0;
            start_o     <= 1'b0;
            cont_o      <= 1'b0;
            susp_o      <= 1'b0;
            desel_o     <= 1'b0;
        end else begin
            start_o <= (ev == EV_START);
            cont_o  <= (ev == EV_STEP);
            susp_o  <= (ev == EV_HOLD);
            desel_o <= (ev == EV_DESEL);
            if (ev == EV_START || ev == EV_STEP)
                word_addr_o <= {base_nx[AW-1:BW], low_nx};
        end
    end

    // R11: one event per edge at most
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, cont_o, susp_o, desel_o}));

    // R2 / R5: a start shows the sampled address at beat zero
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (word_addr_o == $past(addr_i)) && (beat_o == '0));

    // R6: a step advances the beat by exactly one
    a_r6_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
        cont_o |-> beat_o == BW'($past(beat_o) + 1'b1));

    // R6: a suspend freezes address and beat
    a_r6_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> $stable(word_addr_o) && $stable(beat_o));

    // R7: upper bits never move inside a burst
    a_r7_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_o || susp_o) |-> word_addr_o[AW-1:BW] == $past(word_addr_o[AW-1:BW]));

    // R11: a deselect leaves the burst idle on the following edge
    a_r11_desel_idles: assert property (@(posedge clk) disable iff (!rst_n)
        desel_o |=> !cont_o && !susp_o);

    // R12: no event while sleep was sampled high
    a_r12_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep_i) |-> !start_o && !cont_o && !susp_o && !desel_o);

    initial begin
        a_r8_width_split: assert (HI_W > 0);
    end

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 15;
    localparam int BW   = 2;
    localparam int WAKE = 2;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [BW-1:0] beat;
        logic st, co, su, de;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, advance_n = 1'b1;
    logic          ilv_mode_i = 1'b0, sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          sleep_i = 1'b0;
    logic [AW-1:0] word_addr_o;
    logic [BW-1:0] beat_o;
    logic          start_o, cont_o, susp_o, desel_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference model state
    logic [AW-1:0] m_addr = '0, m_base = '0;
    logic [BW-1:0] m_cnt = '0;
    bit            m_active = 0;
    int            m_wake = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .advance_n(advance_n), .ilv_mode_i(ilv_mode_i),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .sleep_i(sleep_i), .word_addr_o(word_addr_o), .beat_o(beat_o),
        .start_o(start_o), .cont_o(cont_o), .susp_o(susp_o), .desel_o(desel_o)
    );

    function automatic logic [AW-1:0] beat_addr(input logic md);
        logic [BW-1:0] lo;
        lo = md ? (m_base[BW-1:0] ^ m_cnt) : BW'(m_base[BW-1:0] + m_cnt);
        return {m_base[AW-1:BW], lo};
    endfunction

    // Driver: applies one edge of stimulus and queues the expected result
    task automatic drive(input logic cpu_n, input logic ctl_n, input logic adv_n,
                         input logic [AW-1:0] a, input logic sa_n, input logic sb,
                         input logic sc_n, input logic slp, input logic md,
                         input string tag);
        exp_t e;
        bit   blocked;
        bit   req;
        @(negedge clk);
        strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n; advance_n = adv_n;
        addr_i = a; sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
        sleep_i = slp; ilv_mode_i = md;
        e = '0;
        if (slp) begin
            m_wake = WAKE;
        end else begin
            blocked = (m_wake > 0);
            if (m_wake > 0) m_wake--;
            req = ((!cpu_n && !sa_n) || (!ctl_n && cpu_n)) && !blocked;
            if (req) begin
                if (!sa_n && sb && !sc_n) begin
                    m_base = a; m_cnt = '0; m_active = 1; e.st = 1;
                    m_addr = beat_addr(md);
                end else begin
                    m_active = 0; e.de = 1;
                end
            end else if (m_active) begin
                if (!adv_n) begin
                    m_cnt = m_cnt + 1'b1; e.co = 1; m_addr = beat_addr(md);
                end else begin
                    e.su = 1;
                end
            end
        end
        e.addr = m_addr;
        e.beat = m_cnt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each result just after the edge that produced it
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (word_addr_o !== e.addr || beat_o !== e.beat ||
                start_o !== e.st || cont_o !== e.co ||
                susp_o !== e.su || desel_o !== e.de) begin
                errors++;
                $display("FAIL %s: addr=%h beat=%0d flags=%b%b%b%b expected addr=%h beat=%0d flags=%b%b%b%b",
                         t, word_addr_o, beat_o, start_o, cont_o, susp_o, desel_o,
                         e.addr, e.beat, e.st, e.co, e.su, e.de);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (word_addr_o !== '0 || beat_o !== '0 ||
            {start_o, cont_o, susp_o, desel_o} !== 4'b0) begin
            errors++;
            $display("FAIL R1: addr=%h beat=%0d flags=%b%b%b%b expected all zero",
                     word_addr_o, beat_o, start_o, cont_o, susp_o, desel_o);
        end

        // R13: idle, no start
        drive(1, 1, 0, 15'h0777, 0, 1, 0, 0, 1, "R13");
        // R2, R5: processor start with advance low, interleaved, start low bits 01
        drive(0, 1, 0, 15'h1235, 0, 1, 0, 0, 1, "R2/R5");
        // R8: interleaved order 00,11,10 ; R7: address input changes
        drive(1, 1, 0, 15'h7FFE, 0, 1, 0, 0, 1, "R8");
        drive(1, 1, 0, 15'h0000, 0, 1, 0, 0, 1, "R8");
        drive(1, 1, 0, 15'h5555, 0, 1, 0, 0, 1, "R8");
        // R10: wrap back to the start value
        drive(1, 1, 0, 15'h2AAA, 0, 1, 0, 0, 1, "R10");
        // R6: suspend, R7: upper bits held
        drive(1, 1, 1, 15'h4321, 0, 1, 0, 0, 1, "R6/R7");
        // R4: controller start with processor strobe high, linear, start 10
        drive(1, 0, 1, 15'h2A46, 0, 1, 0, 0, 0, "R4");
        // R9: linear 11,00,01 then R10 wrap to 10
        drive(1, 1, 0, 15'h0003, 0, 1, 0, 0, 0, "R9");
        drive(1, 1, 0, 15'h0003, 0, 1, 0, 0, 0, "R9");
        drive(1, 1, 0, 15'h0003, 0, 1, 0, 0, 0, "R9");
        drive(1, 1, 0, 15'h0003, 0, 1, 0, 0, 0, "R10");
        drive(1, 1, 0, 15'h0003, 0, 1, 0, 0, 0, "R6");
        // R3/R4: primary select high blocks processor strobe and controller strobe
        drive(0, 0, 1, 15'h1111, 1, 1, 0, 0, 0, "R3");
        drive(0, 1, 0, 15'h1111, 1, 1, 0, 0, 0, "R3");
        // R11/R4: controller strobe with primary select high -> deselect
        drive(1, 0, 0, 15'h1111, 1, 1, 0, 0, 0, "R11");
        drive(1, 1, 0, 15'h1111, 0, 1, 0, 0, 0, "R11");
        // R11: second select low, third select high
        drive(0, 1, 0, 15'h0100, 0, 0, 0, 0, 0, "R11");
        drive(0, 1, 0, 15'h0100, 0, 1, 1, 0, 0, "R11");
        // R2: fresh start for the sleep sequence
        drive(0, 1, 1, 15'h3C01, 0, 1, 0, 0, 1, "R2");
        // R12: sleep holds everything, start and advance ignored
        drive(0, 1, 0, 15'h0F0F, 0, 1, 0, 1, 1, "R12");
        drive(1, 1, 0, 15'h0F0F, 0, 1, 0, 1, 1, "R12");
        // R12: two blocked edges after wake, advance still works
        drive(0, 1, 0, 15'h0F0F, 0, 1, 0, 0, 1, "R12");
        drive(0, 1, 1, 15'h0F0F, 0, 1, 0, 0, 1, "R12");
        // R12: third edge honours the start
        drive(0, 1, 1, 15'h0F0E, 0, 1, 0, 0, 1, "R12");
        drive(1, 1, 1, 15'h0F0E, 0, 1, 0, 0, 1, "R6");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule